// File: doc/BRIEF.md
# Packed lane adder with per-lane greater-or-equal flags

This block performs packed arithmetic on 32-bit words. One operation splits both operands into two 16-bit halves or four 8-bit bytes and adds or subtracts them lane by lane. Each lane is signed or unsigned. Two crossed forms pair each half of A with the opposite half of B. Every arithmetic operation also writes a 4-bit greater-or-equal flag register. A byte-pick operation then uses those stored flags to build a word from A and B, one byte at a time. This lets a later instruction merge data based on an earlier comparison.

An operation is presented with `in_valid` high together with the opcode and both operands. The registered result and `out_done` appear one clock later. The unit has no back-pressure: it accepts a new operation on every cycle that `in_valid` is high, and operations may follow each other with no gap. When a pick follows an arithmetic operation on the very next cycle, it sees the flags that operation just wrote.

Opcode bit 3 selects unsigned (1) or signed (0) arithmetic. Bits 2:0 select the kind of operation: 0 is halfword add, 1 is halfword subtract, 2 is byte add, 3 is byte subtract, 4 is the crossed add/subtract, 5 is the crossed subtract/add, 6 is byte pick and 7 is reserved.

Top module: `simd_ge_unit`

## Requirements
- R1: `out_done` is high in exactly the cycles after a cycle with `in_valid` high. `out_result` and `out_ge` change only at the clock edge that accepts an operation.
- R2: Signed halfword add (opcode 0) and subtract (opcode 1) wrap each half modulo 2^16. Each half's flag is 1 when its full-precision signed result is non-negative, even when the 16-bit result overflows. The upper half's flag goes to `out_ge[3]` and `out_ge[2]`; the lower half's flag goes to `out_ge[1]` and `out_ge[0]`.
- R3: For unsigned halfword add (opcode 8), each half's flag is the carry out of that half. For unsigned halfword subtract (opcode 9), each half's flag is 1 when no borrow occurred. The flags go to the same bit pairs as in R2.
- R4: Byte add (opcode 2 signed, 10 unsigned) and byte subtract (opcode 3 signed, 11 unsigned) work on four independent bytes. `out_ge[n]` is the flag of byte n (bits 8n+7:8n). It follows the signed rule of R2 or the unsigned rule of R3.
- R5: Crossed add/subtract (opcode 4 signed, 12 unsigned) gives an upper half of A[31:16] + B[15:0] and a lower half of A[15:0] − B[31:16]. Flags and bit pairs follow R2 or R3.
- R6: Crossed subtract/add (opcode 5 signed, 13 unsigned) gives an upper half of A[31:16] − B[15:0] and a lower half of A[15:0] + B[31:16]. Flags and bit pairs follow R2 or R3.
- R7: No carry or borrow passes from one lane into the next.
- R8: Byte pick (opcode 6 or 14) sets result byte n to A's byte n when stored flag n is 1, and to B's byte n otherwise. It leaves the flag register unchanged.
- R9: The flag register holds its value on cycles without `in_valid`. The reserved opcodes (7 and 15) also leave it unchanged and give a zero result.
- R10: While reset (`rst_n` low) is applied, `out_result`, `out_ge` and `out_done` are 0.
- R11: A byte pick issued on the cycle right after an arithmetic operation uses the flags written by that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Bit 3 selects unsigned; bits 2:0 select the operation kind |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| out_done | output | 1 | Pulses one cycle after an accepted operation |
| out_result | output | 32 | Registered packed result |
| out_ge | output | 4 | Greater-or-equal flag register |

## Verification
Two functions can meet in the same clock edge: an arithmetic operation writing the flag register, and a byte pick reading it. The bench provokes this by issuing every arithmetic operation with a pick immediately behind it, with no idle cycle between them. The bench judges the pick against flags it computes itself from that arithmetic step. A pick that used the older flags would give a different result on most of the sweep. The sweeps cover halfword values clustered around the signed and unsigned overflow points and a strided grid of byte values.

// File: rtl/simd_ge_pkg.sv
package simd_ge_pkg;

  // operation kind, taken from opcode bits 2:0
  typedef enum logic [2:0] {
    K_ADD16 = 3'd0,
    K_SUB16 = 3'd1,
    K_ADD8  = 3'd2,
    K_SUB8  = 3'd3,
    K_ASX   = 3'd4,
    K_SAX   = 3'd5,
    K_PICK  = 3'd6,
    K_RSV   = 3'd7
  } kind_e;

endpackage

// File: rtl/simd_lane.sv
// One packed lane: add or subtract with a one-bit-wider result for the flag.
module simd_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_b,
  input  logic         do_sub,
  input  logic         is_uns,
  output logic [W-1:0] lane_sum,
  output logic         lane_ge
);
  logic [W:0] ext_a, ext_b, full;

  always_comb begin
    ext_a = {(is_uns ? 1'b0 : lane_a[W-1]), lane_a};
    ext_b = {(is_uns ? 1'b0 : lane_b[W-1]), lane_b};
    full  = do_sub ? (ext_a - ext_b) : (ext_a + ext_b);
  end

  assign lane_sum = full[W-1:0];
  // unsigned add: carry out; otherwise: non-negative full-precision result
  assign lane_ge  = (is_uns && !do_sub) ? full[W] : ~full[W];
endmodule

// File: rtl/simd_byte_pick.sv
// Per-byte merge of two words under a flag mask.
module simd_byte_pick #(
  parameter int BYTE_W = 8,
  parameter int NBYTE  = 4
) (
  input  logic [BYTE_W*NBYTE-1:0] src_a,
  input  logic [BYTE_W*NBYTE-1:0] src_b,
  input  logic [NBYTE-1:0]        take_a,
  output logic [BYTE_W*NBYTE-1:0] picked
);
  for (genvar n = 0; n < NBYTE; n++) begin : g_pick
    assign picked[n*BYTE_W +: BYTE_W] =
      take_a[n] ? src_a[n*BYTE_W +: BYTE_W] : src_b[n*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/simd_ge_unit.sv
module simd_ge_unit #(
  parameter int BYTE_W = 8,
  parameter int NBYTE  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [3:0]              op_code,
  input  logic [BYTE_W*NBYTE-1:0] opnd_a,
  input  logic [BYTE_W*NBYTE-1:0] opnd_b,
  output logic                    out_done,
  output logic [BYTE_W*NBYTE-1:0] out_result,
  output logic [NBYTE-1:0]        out_ge
);
  import simd_ge_pkg::*;

  localparam int DATA_W = BYTE_W * NBYTE;
  localparam int NHALF  = 2;
  localparam int HALF_W = DATA_W / NHALF;
  localparam int BPH    = NBYTE / NHALF;

  kind_e kind;
  logic  uns, xchg, is_half, is_byte;

  assign kind    = kind_e'(op_code[2:0]);
  assign uns     = op_code[3];
  assign xchg    = (kind == K_ASX) || (kind == K_SAX);
  assign is_half = (kind == K_ADD16) || (kind == K_SUB16) || xchg;
  assign is_byte = (kind == K_ADD8) || (kind == K_SUB8);

  // halfword lanes
  logic [DATA_W-1:0] half_res;
  logic [NHALF-1:0]  half_ge;
  logic [NBYTE-1:0]  half_ge_x;

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam int HOTHER = NHALF - 1 - h;
    logic [HALF_W-1:0] b_src;
    logic              sub_h;
    assign b_src = xchg ? opnd_b[HOTHER*HALF_W +: HALF_W] : opnd_b[h*HALF_W +: HALF_W];
    // upper half subtracts in the subtract/add form, lower half in add/subtract form
    assign sub_h = (kind == K_SUB16) || ((h == NHALF - 1) ? (kind == K_SAX) : (kind == K_ASX));
    simd_lane #(.W(HALF_W)) u_lane (
      .lane_a  (opnd_a[h*HALF_W +: HALF_W]),
      .lane_b  (b_src),
      .do_sub  (sub_h),
      .is_uns  (uns),
      .lane_sum(half_res[h*HALF_W +: HALF_W]),
      .lane_ge (half_ge[h])
    );
  end

  for (genvar g = 0; g < NBYTE; g++) begin : g_half_flag
    assign half_ge_x[g] = half_ge[g / BPH];
  end

  // byte lanes
  logic [DATA_W-1:0] byte_res;
  logic [NBYTE-1:0]  byte_ge;

  for (genvar n = 0; n < NBYTE; n++) begin : g_byte
    simd_lane #(.W(BYTE_W)) u_lane (
      .lane_a  (opnd_a[n*BYTE_W +: BYTE_W]),
      .lane_b  (opnd_b[n*BYTE_W +: BYTE_W]),
      .do_sub  (kind == K_SUB8),
      .is_uns  (uns),
      .lane_sum(byte_res[n*BYTE_W +: BYTE_W]),
      .lane_ge (byte_ge[n])
    );
  end

  // byte pick from stored flags
  logic [DATA_W-1:0] pick_res;

  simd_byte_pick #(.BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_pick (
    .src_a (opnd_a),
    .src_b (opnd_b),
    .take_a(out_ge),
    .picked(pick_res)
  );

  logic [DATA_W-1:0] res_d;
  logic [NBYTE-1:0]  ge_d;

  always_comb begin
    res_d = '0;
    ge_d  = out_ge;
    if (is_half) begin
      res_d = half_res;
      ge_d  = half_ge_x;
    end else if (is_byte) begin
      res_d = byte_res;
      ge_d  = byte_ge;
    end else if (kind == K_PICK) begin
      res_d = pick_res;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done   <= 1'b0;
      out_result <= '0;
      out_ge     <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_result <= res_d;
        out_ge     <= ge_d;
      end
    end
  end
endmodule

// File: rtl/simd_ge_unit_chk.sv
module simd_ge_unit_chk #(
  parameter int BYTE_W = 8,
  parameter int NBYTE  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic [3:0]              op_code,
  input logic [BYTE_W*NBYTE-1:0] opnd_a,
  input logic [BYTE_W*NBYTE-1:0] opnd_b,
  input logic                    out_done,
  input logic [BYTE_W*NBYTE-1:0] out_result,
  input logic [NBYTE-1:0]        out_ge
);
  localparam int DATA_W = BYTE_W * NBYTE;

  function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] a,
                                              input logic [DATA_W-1:0] b,
                                              input logic [NBYTE-1:0]  m);
    logic [DATA_W-1:0] r;
    for (int n = 0; n < NBYTE; n++)
      r[n*BYTE_W +: BYTE_W] = m[n] ? a[n*BYTE_W +: BYTE_W] : b[n*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic is_pick, is_half_op;
  assign is_pick    = (op_code[2:0] == 3'd6);
  assign is_half_op = (op_code[2:0] == 3'd0) || (op_code[2:0] == 3'd1) ||
                      (op_code[2:0] == 3'd4) || (op_code[2:0] == 3'd5);

  p_done_after_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);

  p_no_spurious_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);

  p_half_pairs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_half_op) |=> (out_ge[3] == out_ge[2]) && (out_ge[1] == out_ge[0]));

  p_pick_keeps_ge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_pick) |=> $stable(out_ge));

  p_pick_merge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_pick) |=> out_result == merge($past(opnd_a), $past(opnd_b), $past(out_ge)));

  p_idle_keeps_ge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_ge) && $stable(out_result)));

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (out_ge == '0 && !out_done && out_result == '0));
endmodule

bind simd_ge_unit simd_ge_unit_chk #(.BYTE_W(BYTE_W), .NBYTE(NBYTE)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .out_done(out_done),
  .out_result(out_result), .out_ge(out_ge)
);

// File: tb/simd_ge_unit_test.sv
module simd_ge_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic [31:0] opnd_a, opnd_b;
  logic        out_done;
  logic [31:0] out_result;
  logic [3:0]  out_ge;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit ended = 0;
  logic [3:0] model_ge;

  always #10 clk = ~clk;

  simd_ge_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .out_done(out_done),
    .out_result(out_result), .out_ge(out_ge)
  );

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 180000) begin
      bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 180000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // returns {flag, 16-bit wrapped value}
  function automatic logic [16:0] lane_ref(input logic [15:0] x, input logic [15:0] y,
                                           input int w, input bit sub, input bit uns);
    longint m, xv, yv, r;
    bit g;
    m  = longint'(1) << w;
    xv = longint'(x) & (m - 1);
    yv = longint'(y) & (m - 1);
    if (!uns) begin
      if (xv >= m / 2) xv = xv - m;
      if (yv >= m / 2) yv = yv - m;
    end
    r = sub ? (xv - yv) : (xv + yv);
    g = (uns && !sub) ? (r >= m) : (r >= 0);
    return {g, 16'(r & (m - 1))};
  endfunction

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] gi, output logic [31:0] r, output logic [3:0] go);
    logic [16:0] hi, lo, t;
    bit u;
    u  = op[3];
    r  = '0;
    go = gi;
    case (op[2:0])
      3'd0, 3'd1: begin
        hi = lane_ref(a[31:16], b[31:16], 16, op[2:0] == 3'd1, u);
        lo = lane_ref(a[15:0],  b[15:0],  16, op[2:0] == 3'd1, u);
        r = {hi[15:0], lo[15:0]}; go = {hi[16], hi[16], lo[16], lo[16]};
      end
      3'd4: begin
        hi = lane_ref(a[31:16], b[15:0],  16, 1'b0, u);
        lo = lane_ref(a[15:0],  b[31:16], 16, 1'b1, u);
        r = {hi[15:0], lo[15:0]}; go = {hi[16], hi[16], lo[16], lo[16]};
      end
      3'd5: begin
        hi = lane_ref(a[31:16], b[15:0],  16, 1'b1, u);
        lo = lane_ref(a[15:0],  b[31:16], 16, 1'b0, u);
        r = {hi[15:0], lo[15:0]}; go = {hi[16], hi[16], lo[16], lo[16]};
      end
      3'd2, 3'd3: begin
        for (int n = 0; n < 4; n++) begin
          t = lane_ref({8'h00, a[n*8 +: 8]}, {8'h00, b[n*8 +: 8]}, 8, op[2:0] == 3'd3, u);
          r[n*8 +: 8] = t[7:0];
          go[n] = t[16];
        end
      end
      3'd6: begin
        for (int n = 0; n < 4; n++) r[n*8 +: 8] = gi[n] ? a[n*8 +: 8] : b[n*8 +: 8];
      end
      default: begin
        r = '0;
      end
    endcase
  endtask

  function automatic string req_tag(input logic [3:0] op);
    case (op[2:0])
      3'd0, 3'd1: return op[3] ? "R3 R7" : "R2 R7";
      3'd2, 3'd3: return "R4 R7";
      3'd4:       return "R5";
      3'd5:       return "R6";
      3'd6:       return "R8 R11";
      default:    return "R9";
    endcase
  endfunction

  // called right after a falling edge; leaves valid high for back-to-back issue
  task automatic do_op(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] er;
    logic [3:0]  eg;
    model(op, a, b, model_ge, er, eg);
    in_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b;
    @(negedge clk);
    chk("R1", "done", {31'd0, out_done}, 32'd1);
    chk(req_tag(op), $sformatf("result op=%0d", op), out_result, er);
    chk(req_tag(op), $sformatf("flags op=%0d", op), {28'd0, out_ge}, {28'd0, eg});
    model_ge = eg;
  endtask

  task automatic idle_cycle();
    logic [31:0] held;
    held = out_result;
    in_valid = 1'b0; op_code = 4'd0; opnd_a = 32'h8000_0000; opnd_b = 32'h7FFF_FFFF;
    @(negedge clk);
    chk("R1", "idle done", {31'd0, out_done}, 32'd0);
    chk("R9", "idle flags", {28'd0, out_ge}, {28'd0, model_ge});
    chk("R1", "idle result", out_result, held);
  endtask

  function automatic logic [15:0] hv(input int i);
    case (i)
      0: return 16'h0000;  1: return 16'h0001;  2: return 16'h0002;
      3: return 16'h7FFE;  4: return 16'h7FFF;  5: return 16'h8000;
      6: return 16'h8001;  7: return 16'hFFFE;  8: return 16'hFFFF;
      9: return 16'h1234;  10: return 16'hC0DE; default: return 16'h00FF;
    endcase
  endfunction

  function automatic logic [2:0] hk(input int k);
    case (k)
      0: return 3'd0; 1: return 3'd1; 2: return 3'd4; default: return 3'd5;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_code = 4'd0; opnd_a = '0; opnd_b = '0;
    model_ge = 4'd0;
    repeat (3) @(negedge clk);
    // R10: reset state, with a valid request presented during reset
    in_valid = 1'b1; op_code = 4'd8; opnd_a = 32'hFFFF_FFFF; opnd_b = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R10", "reset done",   {31'd0, out_done}, 32'd0);
    chk("R10", "reset result", out_result, 32'd0);
    chk("R10", "reset flags",  {28'd0, out_ge}, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    idle_cycle();

    // R8: pick straight after reset uses all-zero flags (all of B)
    do_op(4'd6, 32'hAABB_CCDD, 32'h1122_3344);

    // halfword sweep, each followed by a pick on the next cycle (R11)
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 4; k++)
        for (int i = 0; i < 12; i++)
          for (int j = 0; j < 12; j++)
            for (int q = 0; q < 12; q++) begin
              logic [31:0] a, b;
              a = {hv(i), hv(j)};
              b = {hv(q), hv((i + j + q) % 12)};
              do_op({u[0], hk(k)}, a, b);
              do_op({u[0], 3'd6}, ~a, b);
            end

    idle_cycle();
    // R9: reserved opcodes leave flags, give zero
    do_op(4'd7, 32'h1234_5678, 32'h9ABC_DEF0);
    do_op(4'd15, 32'hFFFF_FFFF, 32'h0000_0001);
    idle_cycle();

    // byte sweep on a strided grid, each followed by a pick
    for (int u = 0; u < 2; u++)
      for (int k = 0; k < 2; k++)
        for (int x = 0; x < 256; x += 3)
          for (int y = 0; y < 256; y += 3) begin
            logic [7:0] xb, yb;
            logic [31:0] a, b;
            xb = 8'(x); yb = 8'(y);
            a = {xb, yb, xb ^ 8'h5A, ~yb};
            b = {yb, xb, yb + 8'd1, xb};
            do_op({u[0], 2'b01, k[0]}, a, b);
            do_op(4'd14, b, a);
          end

    idle_cycle();
    idle_cycle();
    finish_run();
  end
endmodule